// File: doc/BRIEF.md
# Local Serial Bus Timing Generator

This block produces the clocks and frame pulse for a secondary serial TDM port that always runs at 2.048 Mbps, while the main bus beside it may run at 2.048, 4.096 or 8.192 Mbps. All local timing comes from the main double-rate clock. That clock is presented as a one-cycle strobe `x2_edge`, one strobe per half-period of the main clock.

A divider selection sets how many strobes make one local double-rate half-period: 1, 2 or 4. The local double-rate clock is therefore 4.096 MHz at every main rate. The local bit clock is that clock halved, and one frame is 32 channels of 8 bits. A main frame boundary pulse realigns the whole local frame. The frame pulse style and the sample point of the serial input are each chosen by a small configuration field, independently of the divider.

The block also serialises one byte per channel onto the output line, most significant bit first. It deserialises the input line and delivers each received byte with its channel number.

Top module: `lcl_bus_timing`

## Requirements
- R1: `div_sel` sets the strobes per local half-period D: 0 gives 1, 1 gives 2, 2 and 3 give 4. The local half-period index h advances by one on every D-th `x2_edge` strobe.
- R2: h runs from 0 to 1023 and then wraps to 0. `loc_x2` is high when h is even. `loc_x1` is high when h mod 4 is 0 or 1. `chan_idx` is h/32.
- R3: A `frame_mark` pulse sets h and the strobe prescaler to 0 at the next clock edge, whether or not `x2_edge` is high. Both clocks are then high and `chan_idx` is 0.
- R4: With `sync_sel[1]`=0, the frame window covers h=1023 and h=0, straddling the boundary. With `sync_sel[1]`=1, it covers h=1020..1023, the bit period just before the boundary.
- R5: `loc_sync` equals the window when `sync_sel[0]`=1 (active high) and its inverse when `sync_sel[0]`=0 (active low).
- R6: `loc_tx` carries bit b of channel c, MSB first, while h/4 = c*8+b. `tx_byte` is captured at the edge that starts a channel, which is the byte for channel (`chan_idx`+1) mod 32, and also at the `frame_mark` edge, which is the byte for channel 0.
- R7: `smp_sel` picks the input sample point. The sample is taken at the edge that ends the local half-period whose h mod 4 is 1 for code 0 or 3 (half bit), 2 for code 1 (three quarters) and 3 for code 2 (end of bit).
- R8: After the sample of bit 7 of a channel, `rx_valid` is high for exactly one cycle. In that cycle `rx_byte` holds the eight samples of the channel, first sample in bit 7, and `rx_chan` holds the channel number.
- R9: After reset h=0, the prescaler is 0, `loc_tx`=0 and `rx_valid`=0.
- R10: While `x2_edge` and `frame_mark` are both low, `loc_x2`, `loc_x1` and `chan_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_edge | input | 1 | One strobe per main double-rate clock half-period |
| frame_mark | input | 1 | Main frame boundary pulse |
| div_sel | input | 2 | Divider code |
| sync_sel | input | 2 | Frame pulse style: [1] window, [0] polarity |
| smp_sel | input | 2 | Input sample point code |
| tx_byte | input | 8 | Byte for the next channel to be sent |
| loc_rx | input | 1 | Local serial input |
| loc_x2 | output | 1 | Local double-rate clock |
| loc_x1 | output | 1 | Local bit clock |
| loc_sync | output | 1 | Local frame pulse |
| loc_tx | output | 1 | Local serial output |
| chan_idx | output | 5 | Current local channel |
| rx_byte | output | 8 | Received byte |
| rx_chan | output | 5 | Channel of the received byte |
| rx_valid | output | 1 | Received byte strobe |

## Verification
The local clocks, `chan_idx` and `loc_tx` change on the same edge that advances h, and `loc_sync` follows h in that same cycle. A received byte appears one cycle after the edge that takes its last sample. The bench keeps its own strobe count since the last frame mark and derives h from it after every rising edge. At the following falling edge it compares every output with the value due for that h. It also predicts `rx_valid` from the tick and quarter of the previous cycle, so a pulse one cycle early or late is reported.

// File: rtl/lcl_bus_pkg.sv
package lcl_bus_pkg;

  localparam int unsigned QTR_BITS = 2;

  typedef enum logic [1:0] {
    DIV_BY1     = 2'd0,
    DIV_BY2     = 2'd1,
    DIV_BY4     = 2'd2,
    DIV_BY4_ALT = 2'd3
  } lcl_div_e;

  typedef enum logic [1:0] {
    SMP_HALF     = 2'd0,
    SMP_3QTR     = 2'd1,
    SMP_END      = 2'd2,
    SMP_HALF_ALT = 2'd3
  } lcl_smp_e;

  typedef struct packed {
    logic preceding;
    logic active_high;
  } lcl_sync_t;

  // last prescaler value before a local half-period tick
  function automatic logic [1:0] div_limit(input lcl_div_e d);
    case (d)
      DIV_BY1: return 2'd0;
      DIV_BY2: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // quarter of the bit whose closing edge takes the input sample
  function automatic logic [1:0] smp_quarter(input lcl_smp_e s);
    case (s)
      SMP_3QTR: return 2'd2;
      SMP_END:  return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/lcl_rst_sync.sv
module lcl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lcl_prescale.sv
module lcl_prescale
  import lcl_bus_pkg::*;
#(
  parameter int unsigned PW = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     x2_edge,
  input  logic     frame_mark,
  input  lcl_div_e div_sel,
  output logic     hp_tick
);
  logic [PW-1:0] pre_q, pre_d, lim;
  logic          at_lim;

  always_comb begin
    lim    = PW'(div_limit(div_sel));
    at_lim = (pre_q >= lim);
    hp_tick = x2_edge && !frame_mark && at_lim;
    pre_d = pre_q;
    if (frame_mark)   pre_d = '0;
    else if (x2_edge) pre_d = at_lim ? '0 : pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/lcl_frame_ctr.sv
module lcl_frame_ctr
  import lcl_bus_pkg::*;
#(
  parameter int unsigned CHANNELS = 32,
  parameter int unsigned BITS     = 8,
  localparam int unsigned HP_FRAME = CHANNELS * BITS * (1 << QTR_BITS),
  localparam int unsigned HW       = $clog2(HP_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hp_tick,
  input  logic          frame_mark,
  input  lcl_sync_t     sync_cfg,
  output logic [HW-1:0] cnt,
  output logic          loc_x2,
  output logic          loc_x1,
  output logic          loc_sync
);
  localparam logic [HW-1:0] LAST     = HW'(HP_FRAME - 1);
  localparam logic [HW-1:0] PRE_FROM = HW'(HP_FRAME - 4);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          win;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_mark)   cnt_d = '0;
    else if (hp_tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (sync_cfg.preceding) win = (cnt_q >= PRE_FROM);
    else                    win = (cnt_q == LAST) || (cnt_q == '0);
    loc_sync = sync_cfg.active_high ? win : !win;
  end

  assign cnt    = cnt_q;
  assign loc_x2 = !cnt_q[0];
  assign loc_x1 = !cnt_q[1];
endmodule

// File: rtl/lcl_serdes.sv
module lcl_serdes
  import lcl_bus_pkg::*;
#(
  parameter int unsigned CHANNELS = 32,
  parameter int unsigned BITS     = 8,
  localparam int unsigned BB = $clog2(BITS),
  localparam int unsigned CW = $clog2(CHANNELS),
  localparam int unsigned HW = QTR_BITS + BB + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hp_tick,
  input  logic            frame_mark,
  input  logic [HW-1:0]   cnt,
  input  lcl_smp_e        smp_sel,
  input  logic [BITS-1:0] tx_byte,
  input  logic            loc_rx,
  output logic            loc_tx,
  output logic [BITS-1:0] rx_byte,
  output logic [CW-1:0]   rx_chan,
  output logic            rx_valid
);
  logic [QTR_BITS-1:0] qtr;
  logic [BB-1:0]       bit_f;
  logic [CW-1:0]       chan_f;
  logic                bit_end, last_bit, smp_hit;
  logic [BITS-1:0]     tx_q, tx_d, rsh_q, rsh_d, rb_q, rb_d;
  logic [CW-1:0]       rc_q, rc_d;
  logic                rv_q, rv_d;

  always_comb begin
    qtr      = cnt[QTR_BITS-1:0];
    bit_f    = cnt[QTR_BITS +: BB];
    chan_f   = cnt[QTR_BITS+BB +: CW];
    bit_end  = hp_tick && (qtr == '1);
    last_bit = (bit_f == BB'(BITS - 1));
    smp_hit  = hp_tick && (qtr == QTR_BITS'(smp_quarter(smp_sel)));
  end

  // transmit path: load at channel start, shift at each bit boundary
  always_comb begin
    tx_d = tx_q;
    if (frame_mark)   tx_d = tx_byte;
    else if (bit_end) tx_d = last_bit ? tx_byte : {tx_q[BITS-2:0], 1'b0};
  end

  // receive path: shift in at the chosen point, hand off after the last bit
  always_comb begin
    rsh_d = rsh_q;
    rb_d  = rb_q;
    rc_d  = rc_q;
    rv_d  = 1'b0;
    if (smp_hit) begin
      rsh_d = {rsh_q[BITS-2:0], loc_rx};
      if (last_bit) begin
        rb_d = {rsh_q[BITS-2:0], loc_rx};
        rc_d = chan_f;
        rv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rsh_q <= '0;
      rb_q  <= '0;
      rc_q  <= '0;
      rv_q  <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rsh_q <= rsh_d;
      rb_q  <= rb_d;
      rc_q  <= rc_d;
      rv_q  <= rv_d;
    end
  end

  assign loc_tx   = tx_q[BITS-1];
  assign rx_byte  = rb_q;
  assign rx_chan  = rc_q;
  assign rx_valid = rv_q;
endmodule

// File: rtl/lcl_bus_timing.sv
module lcl_bus_timing
  import lcl_bus_pkg::*;
#(
  parameter int unsigned CHANNELS = 32,
  parameter int unsigned BITS     = 8,
  localparam int unsigned CW = $clog2(CHANNELS),
  localparam int unsigned HW = QTR_BITS + $clog2(BITS) + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x2_edge,
  input  logic            frame_mark,
  input  logic [1:0]      div_sel,
  input  logic [1:0]      sync_sel,
  input  logic [1:0]      smp_sel,
  input  logic [BITS-1:0] tx_byte,
  input  logic            loc_rx,
  output logic            loc_x2,
  output logic            loc_x1,
  output logic            loc_sync,
  output logic            loc_tx,
  output logic [CW-1:0]   chan_idx,
  output logic [BITS-1:0] rx_byte,
  output logic [CW-1:0]   rx_chan,
  output logic            rx_valid
);
  logic          rst_core_n;
  logic          hp_tick;
  logic [HW-1:0] cnt;
  lcl_sync_t     sync_cfg;

  assign sync_cfg = lcl_sync_t'(sync_sel);

  lcl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lcl_prescale #(.PW(2)) u_pre (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .x2_edge    (x2_edge),
    .frame_mark (frame_mark),
    .div_sel    (lcl_div_e'(div_sel)),
    .hp_tick    (hp_tick)
  );

  lcl_frame_ctr #(.CHANNELS(CHANNELS), .BITS(BITS)) u_frm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .hp_tick    (hp_tick),
    .frame_mark (frame_mark),
    .sync_cfg   (sync_cfg),
    .cnt        (cnt),
    .loc_x2     (loc_x2),
    .loc_x1     (loc_x1),
    .loc_sync   (loc_sync)
  );

  lcl_serdes #(.CHANNELS(CHANNELS), .BITS(BITS)) u_ser (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .hp_tick    (hp_tick),
    .frame_mark (frame_mark),
    .cnt        (cnt),
    .smp_sel    (lcl_smp_e'(smp_sel)),
    .tx_byte    (tx_byte),
    .loc_rx     (loc_rx),
    .loc_tx     (loc_tx),
    .rx_byte    (rx_byte),
    .rx_chan    (rx_chan),
    .rx_valid   (rx_valid)
  );

  assign chan_idx = cnt[HW-1 -: CW];
endmodule

// File: rtl/lcl_bus_timing_chk.sv
module lcl_bus_timing_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          x2_edge,
  input logic          frame_mark,
  input logic          loc_x2,
  input logic          loc_x1,
  input logic          loc_tx,
  input logic [CW-1:0] chan_idx,
  input logic          rx_valid
);
  // R1: the local double-rate clock moves only on a strobe or a realignment
  a_r1_x2_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(loc_x2) && !$past(frame_mark)) |-> $past(x2_edge));

  // R2: the bit clock changes only together with the double-rate clock
  a_r2_x1_follows_x2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(loc_x1) && !$past(frame_mark)) |-> !$stable(loc_x2));

  // R3: a frame mark leaves both clocks high at channel 0
  a_r3_mark_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> (loc_x2 && loc_x1 && chan_idx == '0));

  // R6: output data changes only at a bit start or a realignment
  a_r6_tx_at_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(loc_tx) |-> ($rose(loc_x1) || $past(frame_mark)));

  // R8: the received byte strobe lasts a single cycle
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: without strobe or mark the local timing holds
  a_r10_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!x2_edge && !frame_mark) |=> ($stable(loc_x2) && $stable(loc_x1) && $stable(chan_idx)));
endmodule

bind lcl_bus_timing lcl_bus_timing_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .x2_edge    (x2_edge),
  .frame_mark (frame_mark),
  .loc_x2     (loc_x2),
  .loc_x1     (loc_x1),
  .loc_tx     (loc_tx),
  .chan_idx   (chan_idx),
  .rx_valid   (rx_valid)
);

// File: tb/lcl_bus_timing_test.sv
`timescale 1ns/1ps
module lcl_bus_timing_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       x2_edge, frame_mark, loc_rx;
  logic [1:0] div_sel, sync_sel, smp_sel;
  logic [7:0] tx_byte;
  logic       loc_x2, loc_x1, loc_sync, loc_tx, rx_valid;
  logic [4:0] chan_idx, rx_chan;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int s = 0;        // strobes since last mark
  int dv = 1;       // strobes per half-period
  int kq = 1;       // sample quarter
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  lcl_bus_timing uut (
    .clk(clk), .rst_n(rst_n), .x2_edge(x2_edge), .frame_mark(frame_mark),
    .div_sel(div_sel), .sync_sel(sync_sel), .smp_sel(smp_sel),
    .tx_byte(tx_byte), .loc_rx(loc_rx),
    .loc_x2(loc_x2), .loc_x1(loc_x1), .loc_sync(loc_sync), .loc_tx(loc_tx),
    .chan_idx(chan_idx), .rx_byte(rx_byte), .rx_chan(rx_chan), .rx_valid(rx_valid)
  );

  function automatic logic [7:0] pat_tx(input int c);
    return 8'((c * 29 + 90) ^ (c << 3));
  endfunction

  function automatic logic [7:0] pat_rx(input int qt, input int c);
    return 8'(c * 53 + qt * 71 + 17);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d)", tag, act, exp, (s / dv) % 1024);
    end
  endtask

  // one clock: drive at falling edge, model the rising edge, check at next falling edge
  task automatic step(input bit mark, input bit en);
    int  hq;
    bit  tick, ev;
    int  erc, h, exps;
    hq = (s / dv) % 1024;
    x2_edge    = en;
    frame_mark = mark;
    tx_byte    = mark ? pat_tx(0) : pat_tx(((hq >> 5) + 1) % 32);
    loc_rx     = pat_rx(hq & 3, hq >> 5)[7 - ((hq >> 2) & 7)];
    @(posedge clk);
    tick = !mark && en && ((s % dv) == dv - 1);
    ev   = tick && (((hq >> 2) & 7) == 7) && ((hq & 3) == kq);
    erc  = hq >> 5;
    if (mark) s = 0;
    else if (en) s++;
    @(negedge clk);
    h = (s / dv) % 1024;
    chk(loc_x2 == ((h % 2) == 0), "R1 loc_x2", loc_x2, (h % 2) == 0);
    chk(loc_x1 == ((h % 4) < 2), "R2 loc_x1", loc_x1, (h % 4) < 2);
    chk(chan_idx == 5'(h >> 5), "R2 chan_idx", chan_idx, h >> 5);
    exps = sync_sel[1] ? (h >= 1020) : (h == 1023 || h == 0);
    if (!sync_sel[0]) exps = !exps;
    chk(loc_sync == exps[0], sync_sel[1] ? "R4 R5 loc_sync preceding" : "R4 R5 loc_sync straddle",
        loc_sync, exps);
    chk(loc_tx == pat_tx(h >> 5)[7 - ((h >> 2) & 7)], "R6 loc_tx", loc_tx,
        pat_tx(h >> 5)[7 - ((h >> 2) & 7)]);
    chk(rx_valid == ev, "R8 rx_valid timing", rx_valid, ev);
    if (rx_valid && ev) begin
      chk(rx_chan == 5'(erc), "R8 rx_chan", rx_chan, erc);
      chk(rx_byte == pat_rx(kq, erc), "R7 rx_byte sample point", rx_byte, pat_rx(kq, erc));
    end
  endtask

  initial begin
    rst_n = 1'b0; x2_edge = 1'b0; frame_mark = 1'b0; loc_rx = 1'b0;
    div_sel = 2'd0; sync_sel = 2'd0; smp_sel = 2'd0; tx_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state, h=0 and active-low straddle pulse asserted
    chk(loc_x2 && loc_x1, "R9 clocks high", {loc_x2, loc_x1}, 3);
    chk(chan_idx == 0, "R9 chan_idx", chan_idx, 0);
    chk(loc_tx == 1'b0, "R9 loc_tx", loc_tx, 0);
    chk(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    chk(loc_sync == 1'b0, "R9 loc_sync", loc_sync, 0);
    // R10: no strobes, nothing advances
    repeat (10) @(negedge clk);
    chk(loc_x2 && loc_x1 && chan_idx == 0, "R10 hold without strobe", {loc_x2, loc_x1}, 3);

    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 4; i++) begin
        bit gaps;
        int total;
        gaps = (i % 2) == 1;
        div_sel  = 2'(d);
        sync_sel = 2'(i);
        smp_sel  = 2'((i + d) % 4);
        dv = (d == 0) ? 1 : (d == 1) ? 2 : 4;
        kq = (smp_sel == 2'd1) ? 2 : (smp_sel == 2'd2) ? 3 : 1;
        // R3: realign mid-frame, with a strobe-free mark on gapped runs
        step(1'b1, !gaps);
        total = dv * (1024 + 40);
        while (s < total) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          step(1'b0, gaps ? (lfsr[1:0] != 2'b00) : 1'b1);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule